// File: doc/BRIEF.md
# HD-SDI EAV and Line-Number Inserter

This block sits on a 20-bit parallel HD video path. The path is carried as two 10-bit lanes, luma (Y) and chroma (Cb/Cr). On every line of a 1080-line raster with 1920 active samples, the block overwrites six sample slots in both lanes. The first four are the end-of-active-video timing reference. The next two are the encoded line number. Every other sample goes through unchanged, and that includes the CRC slots that follow.

The upstream sample counter tells the block where it is in the line. The field, vertical-blanking and horizontal flags supply the content of the status word. A 22-bit line-number bus carries two 11-bit fields, one for each lane. The luma lane takes its line number from its own field, so the line number appears in the luma lane as well as the chroma lane. Both encoded words of a line come from a copy of the bus taken when the timing reference starts. The block is used ahead of CRC insertion and serialization. It adds one clock of latency to both lanes.

Top module: `hdsdi_lnins`

## Requirements
- R1: While reset is asserted, both `y_out` and `c_out` are 0.
- R2: One cycle after `sample_cnt` is 1920, 1921 or 1922, each lane outputs 3FF, 000 or 000 respectively.
- R3: One cycle after `sample_cnt` is 1923, each lane outputs the status word {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}, bit 9 first. F, V and H are `fld`, `vblk` and `hflag` in that cycle. For example, F=0, V=1, H=1 gives 2D8.
- R4: One cycle after `sample_cnt` is 1924, each lane outputs {~LN[6], LN[6:0], 0, 0}, where LN is that lane's line number. LN=1 gives 204.
- R5: One cycle after `sample_cnt` is 1925, each lane outputs {1, 0, 0, 0, LN[10:7], 0, 0}. Bit 9 is the inverse of the reserved-zero bit 8. LN=1 gives 200.
- R6: The luma lane takes its line number from `ln_bus[21:11]` and the chroma lane from `ln_bus[10:0]`. Different values in the two fields give different words in the two lanes.
- R7: The line number is taken from `ln_bus` in the cycle where `sample_cnt` is 1920. A change on `ln_bus` in later cycles of the same line has no effect on the words output for 1924 and 1925.
- R8: For any other `sample_cnt` value, each output equals its lane's input from one cycle earlier. This includes 1919 and the CRC slots 1926 and 1927.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_cnt | input | 12 | Sample position within the line |
| fld | input | 1 | Field flag for the status word |
| vblk | input | 1 | Vertical-blanking flag for the status word |
| hflag | input | 1 | Horizontal flag for the status word |
| ln_bus | input | 22 | Luma line number in bits 21:11, chroma line number in bits 10:0 |
| y_in | input | 10 | Luma lane input sample |
| c_in | input | 10 | Chroma lane input sample |
| y_out | output | 10 | Luma lane output, one cycle after input |
| c_out | output | 10 | Chroma lane output, one cycle after input |

## Verification
Every output word is due exactly one clock after the sample that produced it. The bench presents each sample on a falling edge, lets one rising edge pass, and compares both lanes on the next falling edge against the word expected for the sample just presented. The line-number words at 1924 and 1925 are computed from the bus value held at 1920, four and five cycles earlier. One scenario changes the bus right after 1920, so a design that samples it late shows the newer value two rising edges before the words are checked.

// File: rtl/hdsdi_pkg.sv
package hdsdi_pkg;

   localparam int WORD_W = 10;
   localparam int LN_BITS = 11;

   typedef enum logic [2:0] {
      SL_PASS,
      SL_PRE_ONES,
      SL_PRE_ZA,
      SL_PRE_ZB,
      SL_STATUS,
      SL_LNUM_LO,
      SL_LNUM_HI
   } slot_e;

   function automatic logic [WORD_W-1:0] status_word(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
   endfunction

   function automatic logic [WORD_W-1:0] lnum_lo_word(input logic [LN_BITS-1:0] ln);
      return {~ln[6], ln[6:0], 2'b00};
   endfunction

   function automatic logic [WORD_W-1:0] lnum_hi_word(input logic [LN_BITS-1:0] ln);
      return {1'b1, 3'b000, ln[10:7], 2'b00};
   endfunction

endpackage

// File: rtl/hdsdi_slot_dec.sv
module hdsdi_slot_dec
   import hdsdi_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int ACTIVE = 1920
) (
   input  logic [CNT_W-1:0] sample_cnt,
   output slot_e            slot,
   output logic             ln_capture
);

   localparam int LAST_SLOT = ACTIVE + 5;
   localparam logic [CNT_W-1:0] P_ONES = CNT_W'(ACTIVE);
   localparam logic [CNT_W-1:0] P_ZA   = CNT_W'(ACTIVE + 1);
   localparam logic [CNT_W-1:0] P_ZB   = CNT_W'(ACTIVE + 2);
   localparam logic [CNT_W-1:0] P_STAT = CNT_W'(ACTIVE + 3);
   localparam logic [CNT_W-1:0] P_LNLO = CNT_W'(ACTIVE + 4);
   localparam logic [CNT_W-1:0] P_LNHI = CNT_W'(ACTIVE + 5);

   generate
      if (LAST_SLOT >= (1 << CNT_W)) begin : g_bad_cnt
         $error("hdsdi_slot_dec: CNT_W too narrow for ACTIVE+5");
      end
   endgenerate

   always_comb begin
      unique case (sample_cnt)
         P_ONES:  slot = SL_PRE_ONES;
         P_ZA:    slot = SL_PRE_ZA;
         P_ZB:    slot = SL_PRE_ZB;
         P_STAT:  slot = SL_STATUS;
         P_LNLO:  slot = SL_LNUM_LO;
         P_LNHI:  slot = SL_LNUM_HI;
         default: slot = SL_PASS;
      endcase
   end

   assign ln_capture = (sample_cnt == P_ONES);

endmodule

// File: rtl/hdsdi_lane.sv
module hdsdi_lane
   import hdsdi_pkg::*;
#(
   parameter int DW   = 10,
   parameter int LN_W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  slot_e               slot,
   input  logic                ln_capture,
   input  logic [LN_W-1:0]     ln_field,
   input  logic [WORD_W-1:0]   stat_w,
   input  logic [DW-1:0]       din,
   output logic [DW-1:0]       dout
);

   localparam int PAD = DW - WORD_W;

   logic [LN_W-1:0]   ln_held;
   logic [WORD_W-1:0] ins_w;
   logic [DW-1:0]     nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ln_held <= '0;
      else if (ln_capture) ln_held <= ln_field;
   end

   always_comb begin
      unique case (slot)
         SL_PRE_ONES: ins_w = '1;
         SL_PRE_ZA:   ins_w = '0;
         SL_PRE_ZB:   ins_w = '0;
         SL_STATUS:   ins_w = stat_w;
         SL_LNUM_LO:  ins_w = lnum_lo_word(ln_held);
         SL_LNUM_HI:  ins_w = lnum_hi_word(ln_held);
         default:     ins_w = '0;
      endcase
   end

   generate
      if (PAD == 0) begin : g_exact
         assign nxt = (slot == SL_PASS) ? din : ins_w;
      end else begin : g_msb_aligned
         assign nxt = (slot == SL_PASS) ? din : {ins_w, {PAD{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else dout <= nxt;
   end

endmodule

// File: rtl/hdsdi_lnins.sv
module hdsdi_lnins
   import hdsdi_pkg::*;
#(
   parameter int DW     = 10,
   parameter int LN_W   = 11,
   parameter int CNT_W  = 12,
   parameter int ACTIVE = 1920
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  sample_cnt,
   input  logic              fld,
   input  logic              vblk,
   input  logic              hflag,
   input  logic [2*LN_W-1:0] ln_bus,
   input  logic [DW-1:0]     y_in,
   input  logic [DW-1:0]     c_in,
   output logic [DW-1:0]     y_out,
   output logic [DW-1:0]     c_out
);

   localparam int LANES = 2;

   generate
      if (DW < WORD_W) begin : g_bad_dw
         $error("hdsdi_lnins: DW must be at least 10");
      end
      if (LN_W != LN_BITS) begin : g_bad_ln
         $error("hdsdi_lnins: LN_W must be 11");
      end
   endgenerate

   slot_e             slot;
   logic              ln_capture;
   logic [WORD_W-1:0] stat_w;
   logic [DW-1:0]     lane_in  [LANES];
   logic [DW-1:0]     lane_out [LANES];

   hdsdi_slot_dec #(.CNT_W(CNT_W), .ACTIVE(ACTIVE)) u_dec (
      .sample_cnt (sample_cnt),
      .slot       (slot),
      .ln_capture (ln_capture)
   );

   assign stat_w     = status_word(fld, vblk, hflag);
   assign lane_in[0] = y_in;
   assign lane_in[1] = c_in;

   // lane 0 (luma) takes the upper field, lane 1 (chroma) the lower
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         hdsdi_lane #(.DW(DW), .LN_W(LN_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot       (slot),
            .ln_capture (ln_capture),
            .ln_field   (ln_bus[(LANES-i)*LN_W-1 -: LN_W]),
            .stat_w     (stat_w),
            .din        (lane_in[i]),
            .dout       (lane_out[i])
         );
      end
   endgenerate

   assign y_out = lane_out[0];
   assign c_out = lane_out[1];

endmodule

// File: rtl/hdsdi_lnins_chk.sv
module hdsdi_lnins_chk #(
   parameter int DW     = 10,
   parameter int CNT_W  = 12,
   parameter int ACTIVE = 1920
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] sample_cnt,
   input logic             fld,
   input logic             vblk,
   input logic             hflag,
   input logic [DW-1:0]    y_in,
   input logic [DW-1:0]    c_in,
   input logic [DW-1:0]    y_out,
   input logic [DW-1:0]    c_out
);

   localparam logic [CNT_W-1:0] Q0 = CNT_W'(ACTIVE);
   localparam logic [CNT_W-1:0] Q1 = CNT_W'(ACTIVE + 1);
   localparam logic [CNT_W-1:0] Q2 = CNT_W'(ACTIVE + 2);
   localparam logic [CNT_W-1:0] Q3 = CNT_W'(ACTIVE + 3);
   localparam logic [CNT_W-1:0] Q4 = CNT_W'(ACTIVE + 4);
   localparam logic [CNT_W-1:0] Q5 = CNT_W'(ACTIVE + 5);

   always_comb begin
      if (!rst_n) begin
         AST_RESET_ZERO: assert (y_out == '0 && c_out == '0); // R1
      end
   end

   AST_PRE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt == Q0) |=> (&y_out[DW-1 -: 10]) && (&c_out[DW-1 -: 10])); // R2

   AST_PRE_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt == Q1 || sample_cnt == Q2) |=> (y_out == '0 && c_out == '0)); // R2

   AST_STATUS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt == Q3) |=> (y_out == c_out && y_out[DW-1] &&
                              y_out[DW-2] == $past(fld) &&
                              y_out[DW-3] == $past(vblk) &&
                              y_out[DW-4] == $past(hflag))); // R3

   AST_LNLO_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt == Q4) |=> (y_out[DW-1] != y_out[DW-2] && c_out[DW-1] != c_out[DW-2])); // R4

   AST_LNHI_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt == Q5) |=> (y_out[DW-1 -: 4] == 4'b1000 && c_out[DW-1 -: 4] == 4'b1000)); // R5

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_cnt < Q0 || sample_cnt > Q5) |=> (y_out == $past(y_in) && c_out == $past(c_in))); // R8

endmodule

bind hdsdi_lnins hdsdi_lnins_chk #(.DW(DW), .CNT_W(CNT_W), .ACTIVE(ACTIVE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_cnt (sample_cnt),
   .fld        (fld),
   .vblk       (vblk),
   .hflag      (hflag),
   .y_in       (y_in),
   .c_in       (c_in),
   .y_out      (y_out),
   .c_out      (c_out)
);

// File: tb/sim_hdsdi_lnins.sv
module sim_hdsdi_lnins;

   localparam int ACT = 1920;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] sample_cnt = '0;
   logic        fld = 1'b0, vblk = 1'b0, hflag = 1'b0;
   logic [21:0] ln_bus = '0;
   logic [9:0]  y_in = '0, c_in = '0;
   logic [9:0]  y_out, c_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   hdsdi_lnins u0 (
      .clk(clk), .rst_n(rst_n), .sample_cnt(sample_cnt),
      .fld(fld), .vblk(vblk), .hflag(hflag), .ln_bus(ln_bus),
      .y_in(y_in), .c_in(c_in), .y_out(y_out), .c_out(c_out)
   );

   function automatic logic [9:0] exp_status(logic f, logic v, logic h);
      logic [9:0] w;
      w[9] = 1'b1; w[8] = f; w[7] = v; w[6] = h;
      w[5] = v ^ h; w[4] = f ^ h; w[3] = f ^ v; w[2] = f ^ v ^ h;
      w[1:0] = 2'b00;
      return w;
   endfunction

   function automatic logic [9:0] exp_lo(logic [10:0] ln);
      return (ln[6] ? 10'h000 : 10'h200) | (10'(ln[6:0]) << 2);
   endfunction

   function automatic logic [9:0] exp_hi(logic [10:0] ln);
      return 10'h200 | (10'(ln[10:7]) << 2);
   endfunction

   task automatic chk(string req, string what, logic [9:0] got, logic [9:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic string tag_for(int k);
      if (k == ACT || k == ACT + 1 || k == ACT + 2) return "R2";
      if (k == ACT + 3) return "R3";
      if (k == ACT + 4) return "R4/R6/R7";
      if (k == ACT + 5) return "R5/R6/R7";
      return "R8";
   endfunction

   // Sweep one line window; lny/lnc are the fields present at sample ACT.
   task automatic run_line(string name, logic f, logic v, logic h,
                           logic [10:0] lny, logic [10:0] lnc,
                           bit late, logic [21:0] late_bus, int seed);
      logic [9:0] yd, cd, ey, ec;
      fld = f; vblk = v; hflag = h;
      ln_bus = {lny, lnc};
      for (int k = ACT - 3; k <= ACT + 8; k++) begin
         yd = 10'((k * 37 + seed) & 10'h3FF);
         cd = 10'((k * 53 + seed * 3 + 5) & 10'h3FF);
         sample_cnt = 12'(k);
         y_in = yd;
         c_in = cd;
         if (late && k == ACT + 1) ln_bus = late_bus;
         @(negedge clk);
         if (k == ACT) begin ey = 10'h3FF; ec = 10'h3FF; end
         else if (k == ACT + 1 || k == ACT + 2) begin ey = 10'h000; ec = 10'h000; end
         else if (k == ACT + 3) begin ey = exp_status(f, v, h); ec = ey; end
         else if (k == ACT + 4) begin ey = exp_lo(lny); ec = exp_lo(lnc); end
         else if (k == ACT + 5) begin ey = exp_hi(lny); ec = exp_hi(lnc); end
         else begin ey = yd; ec = cd; end
         chk(tag_for(k), $sformatf("%s Y@%0d", name, k), y_out, ey);
         chk(tag_for(k), $sformatf("%s C@%0d", name, k), c_out, ec);
      end
   endtask

   task automatic t_reset();
      y_in = 10'h155; c_in = 10'h2AA; sample_cnt = 12'd5;
      repeat (3) @(negedge clk);
      chk("R1", "reset y_out", y_out, 10'h000);
      chk("R1", "reset c_out", c_out, 10'h000);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R3 example: F0 V1 H1 gives 2D8; R4/R5 example: LN 1 gives 204 / 200
   task automatic t_known_words();
      run_line("ln1", 1'b0, 1'b1, 1'b1, 11'd1, 11'd1, 1'b0, '0, 7);
      chk("R3", "status literal", exp_status(1'b0, 1'b1, 1'b1), 10'h2D8);
   endtask

   task automatic t_split_fields();   // R6: different luma and chroma numbers
      run_line("split", 1'b1, 1'b0, 1'b1, 11'd127, 11'd128, 1'b0, '0, 19);
      run_line("swap", 1'b0, 1'b0, 1'b0, 11'd128, 11'd127, 1'b0, '0, 44);
   endtask

   task automatic t_high_line();      // R4, R5 with upper line-number bits set
      run_line("ln1125", 1'b1, 1'b1, 1'b1, 11'd1125, 11'd1125, 1'b0, '0, 91);
   endtask

   task automatic t_late_change();    // R7: bus change after 1920 is ignored
      run_line("late", 1'b1, 1'b1, 1'b0, 11'd563, 11'd20, 1'b1, {11'd1000, 11'd777}, 3);
   endtask

   initial begin
      t_reset();
      t_known_words();
      t_split_fields();
      t_high_line();
      t_late_change();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule